// File: doc/BRIEF.md
# DMA Repeat-Window Source Address Generator

This block produces the source address for one DMA channel and keeps it inside a power-of-two window. A 5-bit window code says how many low address bits may count. The bits above them hold the value they were loaded with. Each accepted transfer strobe advances the address by one byte. When the counting bits pass their all-ones value, they return to zero. That return is an overflow. If the overflow interrupt is enabled, the overflow raises an interrupt request and halts the channel.

The channel runs in one of two modes. In single-unit mode, every strobe is a complete unit, and the transfer count drops by one per strobe. In block mode, a block is a programmed number of strobes. The count drops by one per finished block. An overflow that happens part-way through a block is held pending, and the remaining units of that block still go out past the wrap. The interrupt and the halt take effect at the block boundary. A halt lands exactly on the wrap only when the block size is a power of two no larger than the window and the blocks start on window boundaries. Otherwise the channel overruns the wrap.

A one-cycle start pulse loads all settings. After that, the channel is driven only by strobes, and an interrupt is removed only by the clear input.

Top module: `dma_rpt_addr_gen`

## Requirements
- R1: After reset, `addr` is 0 and `blk_done`, `done` and `irq` are all 0.
- R2: One cycle after a `start` pulse, `addr` equals `start_addr`. `done` is 0 if `xfer_count` is nonzero, and 1 if `xfer_count` is zero.
- R3: With a window code w from 1 to 23, each strobe increments the low w bits of `addr` and wraps them from all ones to zero. Bits w and above do not change. A code of 24 or more makes all 24 bits the window.
- R4: With a window code of 0, each strobe increments the whole address, and the carry propagates into every bit.
- R5: In single-unit mode (`blk_mode`=0) with `irq_en`=1, the strobe that wraps the window sets `irq` and `done` in the same cycle that the wrapped address appears.
- R6: With `irq_en`=0, a wrap raises no interrupt and does not stop the channel. The channel runs until the count is used up.
- R7: In single-unit mode, the channel sets `done` in the cycle after the strobe numbered `xfer_count`.
- R8: In block mode, `blk_done` pulses for one cycle after every `blk_size`-th strobe (a `blk_size` of 0 means 256 strobes). The count drops by one per block, and `done` rises with the last block's `blk_done`.
- R9: In block mode with `irq_en`=1, a wrap before the last unit of a block leaves `irq` and `done` low. Both rise together with that block's `blk_done`. The address keeps advancing past the wrap until the block ends.
- R10: Once set, `irq` stays high until a cycle in which `irq_clr` is 1. Clearing it does not restart the channel.
- R11: Once the channel is done, strobes have no effect, and `addr` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that loads the settings and arms the channel |
| start_addr | input | 24 | First source address |
| win_code | input | 5 | Number of low address bits in the repeat window (0 = no window) |
| blk_mode | input | 1 | 1 = block mode, 0 = single-unit mode |
| blk_size | input | 8 | Units per block (0 = 256) |
| xfer_count | input | 16 | Number of units (single-unit mode) or blocks (block mode) |
| irq_en | input | 1 | Enables the overflow interrupt and the halt on overflow |
| strobe | input | 1 | One pulse per transferred byte |
| irq_clr | input | 1 | Clears the interrupt request |
| addr | output | 24 | Current source address |
| blk_done | output | 1 | One-cycle pulse when a block completes |
| done | output | 1 | Channel has stopped |
| irq | output | 1 | Overflow interrupt request |

## Verification
Every output comes from a register that is loaded on the clock edge that takes `start`, `strobe` or `irq_clr`. As a result, the effect of each stimulus is due exactly one cycle later, and the address, the block pulse, done and the interrupt all change together. The driver applies each stimulus just after a falling edge. Right after the rising edge that consumes it, the driver queues the expected outputs. The monitor pops and compares the queued entries at the next falling edge, which is mid-cycle, so both the one-cycle latency and the single-cycle width of `blk_done` are checked. The cycles that test ignored strobes and the held interrupt push entries of their own, so a stray change in any of these cycles is caught.

// File: rtl/dma_rpt_addr_gen.sv
module dma_rpt_addr_gen #(
  parameter int AW = 24,
  parameter int CW = 16,
  parameter int BW = 8,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [SW-1:0] win_code,
  input  logic          blk_mode,
  input  logic [BW-1:0] blk_size,
  input  logic [CW-1:0] xfer_count,
  input  logic          irq_en,
  input  logic          strobe,
  input  logic          irq_clr,
  output logic [AW-1:0] addr,
  output logic          blk_done,
  output logic          done,
  output logic          irq
);
  localparam logic [AW-1:0] ONES = '1;

  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] left_q, bsize_q;
  logic [SW-1:0] win_q;
  logic          bmode_q, ien_q, act_q, pend_q, done_q, irq_q, bdone_q;

  logic [AW-1:0] win_mask, inc, next_addr;
  logic          wrap, take, blk_last, unit_end, stop_irq, count_end;

  assign win_mask  = (win_q == '0) ? '0 :
                     (int'(win_q) >= AW) ? ONES : ~(ONES << win_q);
  assign inc       = addr_q + AW'(1);
  assign wrap      = (win_q != '0) && ((addr_q & win_mask) == win_mask);
  assign next_addr = (win_q == '0) ? inc : ((addr_q & ~win_mask) | (inc & win_mask));
  assign take      = act_q && strobe;
  assign blk_last  = bmode_q ? (left_q == BW'(1)) : 1'b1;
  assign unit_end  = take && blk_last;
  assign stop_irq  = unit_end && ien_q && (wrap || pend_q);
  assign count_end = unit_end && (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      cnt_q   <= '0;
      left_q  <= '0;
      bsize_q <= '0;
      win_q   <= '0;
      bmode_q <= 1'b0;
      ien_q   <= 1'b0;
      act_q   <= 1'b0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
      bdone_q <= 1'b0;
    end else begin
      bdone_q <= 1'b0;
      if (irq_clr) irq_q <= 1'b0;
      if (start) begin
        addr_q  <= start_addr;
        cnt_q   <= xfer_count;
        left_q  <= blk_size;
        bsize_q <= blk_size;
        win_q   <= win_code;
        bmode_q <= blk_mode;
        ien_q   <= irq_en;
        pend_q  <= 1'b0;
        act_q   <= (xfer_count != '0);
        done_q  <= (xfer_count == '0);
      end else if (take) begin
        addr_q <= next_addr;
        if (bmode_q) left_q <= blk_last ? bsize_q : left_q - BW'(1);
        if (wrap && !blk_last) pend_q <= 1'b1;
        if (unit_end) begin
          pend_q  <= 1'b0;
          cnt_q   <= cnt_q - CW'(1);
          bdone_q <= bmode_q;
          if (stop_irq || count_end) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;
          end
          if (stop_irq) irq_q <= 1'b1;
        end
      end
    end
  end

  assign addr     = addr_q;
  assign blk_done = bdone_q;
  assign done     = done_q;
  assign irq      = irq_q;

  // R3
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !start && win_q != '0) |=>
      ((addr_q & ~$past(win_mask)) == ($past(addr_q) & ~$past(win_mask))));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && !start) |=> $stable(addr_q));

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_clr) |=> irq_q);

  // R9
  blk_irq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bmode_q && $rose(irq_q)) |-> (bdone_q && done_q));

  // R6
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(ien_q));
endmodule

// File: tb/dma_rpt_addr_gen_tb_top.sv
module dma_rpt_addr_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, blk_mode = 1'b0, irq_en = 1'b0, strobe = 1'b0, irq_clr = 1'b0;
  logic [23:0] start_addr = '0;
  logic [4:0]  win_code = '0;
  logic [7:0]  blk_size = '0;
  logic [15:0] xfer_count = '0;
  logic [23:0] addr;
  logic        blk_done, done, irq;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  logic [23:0] q_addr[$];
  logic [2:0]  q_flag[$];
  string       q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_rpt_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .win_code(win_code), .blk_mode(blk_mode), .blk_size(blk_size),
    .xfer_count(xfer_count), .irq_en(irq_en), .strobe(strobe),
    .irq_clr(irq_clr), .addr(addr), .blk_done(blk_done), .done(done), .irq(irq)
  );

  always @(negedge clk) begin
    while (q_addr.size() > 0) begin
      logic [23:0] ea;
      logic [2:0]  ef;
      string       t;
      ea = q_addr.pop_front();
      ef = q_flag.pop_front();
      t  = q_tag.pop_front();
      n_tests++;
      if (addr !== ea || {blk_done, done, irq} !== ef) begin
        n_fail++;
        $display("FAIL %s: addr=%h bd/done/irq=%b expected addr=%h bd/done/irq=%b",
                 t, addr, {blk_done, done, irq}, ea, ef);
      end
    end
  end

  task automatic expect_now(input logic [23:0] a, input logic bd, input logic dn,
                            input logic iq, input string tag);
    q_addr.push_back(a);
    q_flag.push_back({bd, dn, iq});
    q_tag.push_back(tag);
  endtask

  task automatic cyc(input logic s, input logic st, input logic clr, input logic [23:0] a,
                     input logic bd, input logic dn, input logic iq, input string tag);
    @(negedge clk);
    strobe = s; start = st; irq_clr = clr;
    @(posedge clk);
    #1;
    strobe = 0; start = 0; irq_clr = 0;
    expect_now(a, bd, dn, iq, tag);
  endtask

  task automatic setup(input logic [23:0] sa, input logic [4:0] wc, input logic bm,
                       input logic [7:0] bs, input logic [15:0] cnt, input logic ie);
    start_addr = sa; win_code = wc; blk_mode = bm; blk_size = bs;
    xfer_count = cnt; irq_en = ie;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    expect_now(24'h0, 0, 0, 0, "R1 reset");

    // R4 free increment, R7 count
    setup(24'h00FFFE, 5'd0, 0, 8'd0, 16'd4, 1);
    cyc(0, 1, 0, 24'h00FFFE, 0, 0, 0, "R2 load");
    cyc(1, 0, 0, 24'h00FFFF, 0, 0, 0, "R4 step");
    cyc(1, 0, 0, 24'h010000, 0, 0, 0, "R4 carry");
    cyc(1, 0, 0, 24'h010001, 0, 0, 0, "R7 not yet");
    cyc(1, 0, 0, 24'h010002, 0, 1, 0, "R7 done");
    cyc(1, 0, 0, 24'h010002, 0, 1, 0, "R11 ignored");

    // R5 normal overflow stop
    setup(24'h240005, 5'd3, 0, 8'd0, 16'd10, 1);
    cyc(0, 1, 0, 24'h240005, 0, 0, 0, "R2 load");
    cyc(1, 0, 0, 24'h240006, 0, 0, 0, "R3 step");
    cyc(1, 0, 0, 24'h240007, 0, 0, 0, "R3 step");
    cyc(1, 0, 0, 24'h240000, 0, 1, 1, "R5 wrap stop");
    cyc(1, 0, 0, 24'h240000, 0, 1, 1, "R11 ignored");
    cyc(0, 0, 0, 24'h240000, 0, 1, 1, "R10 held");
    cyc(0, 0, 1, 24'h240000, 0, 1, 0, "R10 cleared");
    cyc(1, 0, 0, 24'h240000, 0, 1, 0, "R10 no restart");

    // R6 no interrupt, upper bits fixed
    setup(24'h23FFFE, 5'd3, 0, 8'd0, 16'd3, 0);
    cyc(0, 1, 0, 24'h23FFFE, 0, 0, 0, "R2 load");
    cyc(1, 0, 0, 24'h23FFFF, 0, 0, 0, "R3 step");
    cyc(1, 0, 0, 24'h23FFF8, 0, 0, 0, "R6 wrap runs");
    cyc(1, 0, 0, 24'h23FFF9, 0, 1, 0, "R6 done by count");

    // R9 deferred overflow, block of 5 in 8-byte window
    setup(24'h240000, 5'd3, 1, 8'd5, 16'd3, 1);
    cyc(0, 1, 0, 24'h240000, 0, 0, 0, "R2 load");
    for (int i = 1; i <= 5; i++)
      cyc(1, 0, 0, 24'h240000 + 24'(i), (i == 5), 0, 0, "R8 block1");
    cyc(1, 0, 0, 24'h240006, 0, 0, 0, "R9 block2");
    cyc(1, 0, 0, 24'h240007, 0, 0, 0, "R9 block2");
    cyc(1, 0, 0, 24'h240000, 0, 0, 0, "R9 wrap deferred");
    cyc(1, 0, 0, 24'h240001, 0, 0, 0, "R9 overrun");
    cyc(1, 0, 0, 24'h240002, 1, 1, 1, "R9 irq at boundary");
    cyc(1, 0, 0, 24'h240002, 0, 1, 1, "R11 ignored");
    cyc(0, 0, 1, 24'h240002, 0, 1, 0, "R10 cleared");

    // R6 in block mode
    setup(24'h240000, 5'd3, 1, 8'd5, 16'd2, 0);
    cyc(0, 1, 0, 24'h240000, 0, 0, 0, "R2 load");
    for (int i = 1; i <= 10; i++)
      cyc(1, 0, 0, 24'h240000 + 24'(i % 8), (i == 5 || i == 10), (i == 10), 0, "R6 block");

    // aligned power-of-two block stops on the wrap
    setup(24'h240000, 5'd3, 1, 8'd4, 16'd5, 1);
    cyc(0, 1, 0, 24'h240000, 0, 0, 0, "R2 load");
    for (int i = 1; i <= 8; i++)
      cyc(1, 0, 0, 24'h240000 + 24'(i % 8), (i == 4 || i == 8), (i == 8), (i == 8), "R9 aligned");
    cyc(0, 0, 1, 24'h240000, 0, 1, 0, "R10 cleared");

    // zero count
    setup(24'h123456, 5'd3, 0, 8'd0, 16'd0, 1);
    cyc(0, 1, 0, 24'h123456, 0, 1, 0, "R2 zero count");
    cyc(1, 0, 0, 24'h123456, 0, 1, 0, "R11 ignored");

    // 256-unit block
    setup(24'h000000, 5'd0, 1, 8'd0, 16'd1, 1);
    cyc(0, 1, 0, 24'h000000, 0, 0, 0, "R2 load");
    for (int i = 1; i <= 256; i++)
      cyc(1, 0, 0, 24'(i), (i == 256), (i == 256), 0, "R8 size 256");

    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule